// File: doc/BRIEF.md
# Line Printer Status and Control Register

This block is a single 16-bit register that a CPU sees on a simple register bus. It reports two conditions from a line printer: a fault flag and a ready-for-next-line flag. It also holds one control bit that software may change, the interrupt enable. The two device flags arrive asynchronously. Each one passes through a synchronizer before the register shows it or uses it to detect an edge.

The fault flag sits in the most significant bit. Software can therefore find a fault with one signed test: the register read as a signed 16-bit number is negative. When the enable is set, a rising edge of either device flag raises a level interrupt request. The request stays high until the CPU reads the register or writes the enable to 0. If software turns the enable on while a flag is already high, the request rises at once, so a pending condition is not lost.

Bus reads are registered. Read data appears one clock after the read strobe, and that same read clears the request.

Top module: `lp_status_ctrl`

## Requirements
- R1: After a synchronous reset, the interrupt enable is 0, the request output is 0 and the read data is 0x0000.
- R2: A read at the register address returns fault in bit 15, ready in bit 7 and interrupt enable in bit 6, with every other bit 0. The bits show the synchronized flags, which lag the device pins by two clocks.
- R3: The read value taken as a signed 16-bit number is negative exactly when the fault flag is 1.
- R4: A write at the register address changes only bit 6. The other written bits have no effect: writing 0xFFBF leaves enable at 0, and writing 0xFFFF sets only enable.
- R5: With enable at 1, a rising edge on the ready pin sets the request on the third rising clock edge after the pin changes, and not before.
- R6: With enable at 1, a rising edge on the fault pin sets the request with the same latency as R5.
- R7: With enable at 0, edges on the device pins never set the request.
- R8: A read at the register address clears the request on the same edge that loads the read data, unless a new set event happens in that cycle.
- R9: Writing bit 6 as 0 at the register address clears the request on the next edge. This takes priority over every set event.
- R10: Writing enable from 0 to 1 while ready or fault is already high sets the request on the next edge.
- R11: Reads and writes at any other address leave enable and the request unchanged, and such a read returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_done | input | 1 | Printer ready for next line, asynchronous |
| dev_error | input | 1 | Printer fault, asynchronous |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The request path is driven in four ways:
- A ready edge and a fault edge, each with enable set, check that either source alone raises the request and with what latency.
- The same edges with enable cleared show that the enable gates them.
- Turning the enable on over a flag that is already high tells an edge-only implementation apart from one that also arms on the current level.
- Writes of all-ones and all-but-bit-6, and accesses at a foreign address, show that only bit 6 of the matching address is writable, and that a foreign read neither returns status nor clears the request.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned LP_DATA_W = 16;
  localparam int unsigned LP_DONE_POS = 7;
  localparam int unsigned LP_IE_POS = 6;
  localparam int unsigned LP_ERR_POS = LP_DATA_W - 1;

  typedef logic [LP_DATA_W-1:0] lp_word_t;

  typedef struct packed {
    logic err;
    logic done;
  } lp_status_t;

  function automatic lp_word_t lp_pack(input lp_status_t st, input logic ie);
    lp_word_t w;
    w = '0;
    w[LP_ERR_POS] = st.err;
    w[LP_DONE_POS] = st.done;
    w[LP_IE_POS] = ie;
    return w;
  endfunction
endpackage

// File: rtl/lp_sync_bank.sv
module lp_sync_bank #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lp_irq_ctrl.sv
module lp_irq_ctrl #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] lvl,
  input  logic            ctl_wr,
  input  logic            ctl_val,
  input  logic            ctl_rd,
  output logic            ie_q,
  output logic            irq_q
);
  logic [NSRC-1:0] lvl_prev;
  logic            any_rise;
  logic            any_lvl;
  logic            arm_now;
  logic            set_ev;
  logic            irq_nxt;

  assign any_rise = |(lvl & ~lvl_prev);
  assign any_lvl  = |lvl;
  assign arm_now  = ctl_wr & ctl_val & ~ie_q & any_lvl;
  assign set_ev   = (ie_q & any_rise) | arm_now;

  always_comb begin
    irq_nxt = irq_q;
    if (ctl_wr && !ctl_val) irq_nxt = 1'b0;
    else if (set_ev)        irq_nxt = 1'b1;
    else if (ctl_rd)        irq_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= '0;
      ie_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      lvl_prev <= lvl;
      irq_q    <= irq_nxt;
      if (ctl_wr) ie_q <= ctl_val;
    end
  end
endmodule

// File: rtl/lp_read_port.sv
module lp_read_port
  import lp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_en,
  input  logic       rd_hit,
  input  lp_status_t st,
  input  logic       ie,
  output lp_word_t   rdata_q
);
  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_hit ? lp_pack(st, ie) : '0;
  end
endmodule

// File: rtl/lp_status_ctrl.sv
module lp_status_ctrl
  import lp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned REG_ADDR    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dev_done,
  input  logic                 dev_error,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [LP_DATA_W-1:0] bus_wdata,
  output logic [LP_DATA_W-1:0] bus_rdata,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic       hit;
  logic       reg_wr;
  logic       reg_rd;
  logic [1:0] sync_q;
  logic       done_s;
  logic       err_s;
  logic       ie_q;
  lp_status_t st;

  assign hit    = (bus_addr == MY_ADDR);
  assign reg_wr = bus_we & hit;
  assign reg_rd = bus_re & hit;

  lp_sync_bank #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({dev_error, dev_done}),
    .q_sync  (sync_q)
  );

  assign err_s   = sync_q[1];
  assign done_s  = sync_q[0];
  assign st.err  = err_s;
  assign st.done = done_s;

  lp_irq_ctrl #(.NSRC(2)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .lvl     (sync_q),
    .ctl_wr  (reg_wr),
    .ctl_val (bus_wdata[LP_IE_POS]),
    .ctl_rd  (reg_rd),
    .ie_q    (ie_q),
    .irq_q   (irq)
  );

  lp_read_port u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_re),
    .rd_hit  (hit),
    .st      (st),
    .ie      (ie_q),
    .rdata_q (bus_rdata)
  );
endmodule

// File: rtl/lp_status_chk.sv
module lp_status_chk
  import lp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned REG_ADDR = 0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic                 bus_re,
  input logic [LP_DATA_W-1:0] bus_wdata,
  input logic [LP_DATA_W-1:0] bus_rdata,
  input logic                 irq,
  input logic                 done_s,
  input logic                 err_s,
  input logic                 ie_q
);
  localparam logic [LP_DATA_W-1:0] USED_MASK =
    LP_DATA_W'((1 << LP_ERR_POS) | (1 << LP_DONE_POS) | (1 << LP_IE_POS));
  logic hit;
  assign hit = (bus_addr == ADDR_W'(REG_ADDR));

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq && bus_rdata == '0)); // R1
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~USED_MASK) == '0); // R2
  AST_SIGN_IS_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_re && hit) |=> (bus_rdata[LP_ERR_POS] == $past(err_s))); // R3
  AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!ie_q && !(bus_we && hit)) |=> !$rose(irq)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_re && hit && !bus_we &&
     !(ie_q && ((done_s && !$past(done_s)) || (err_s && !$past(err_s))))) |=> !irq); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit && !bus_wdata[LP_IE_POS]) |=> !irq); // R9
  AST_FOREIGN_IE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!(bus_we && hit)) |=> $stable(ie_q)); // R11
endmodule

bind lp_status_ctrl lp_status_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .done_s    (done_s),
  .err_s     (err_s),
  .ie_q      (ie_q)
);

// File: tb/lp_status_ctrl_tb.sv
module lp_status_ctrl_tb;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              dev_done = 1'b0;
  logic              dev_error = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic              bus_re = 1'b0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  lp_status_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(0), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .dev_done(dev_done), .dev_error(dev_error),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick(1);
    bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [15:0] exp, input string req);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    tick(1);
    bus_re = 1'b0; bus_addr = '0;
  endtask

  // Monitor: pops one expected word per read strobe seen at an edge.
  always begin
    @(posedge clk);
    if (bus_re) begin
      @(negedge clk);
      begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual 0x%04h expected 0x%04h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk_bit("R1 irq", irq, 1'b0);
    chk_bit("R1 rdata", bus_rdata == 16'h0000, 1'b1);
    bus_read(0, 16'h0000, "R1 read");

    // R7 edge with enable off
    dev_done = 1'b1;
    tick(4);
    chk_bit("R7 irq", irq, 1'b0);
    bus_read(0, 16'h0080, "R2 layout done");

    // R10 arm while level high
    bus_write(0, 16'h0040);
    chk_bit("R10 irq", irq, 1'b1);
    bus_read(0, 16'h00C0, "R2 layout done+ie");
    chk_bit("R8 irq cleared", irq, 1'b0);

    // R5 ready edge latency
    dev_done = 1'b0;
    tick(4);
    chk_bit("R5 no irq on fall", irq, 1'b0);
    dev_done = 1'b1;
    tick(2);
    chk_bit("R5 not early", irq, 1'b0);
    tick(1);
    chk_bit("R5 irq", irq, 1'b1);

    // R9 disable clears
    bus_write(0, 16'h0000);
    chk_bit("R9 irq", irq, 1'b0);
    bus_read(0, 16'h0080, "R9 ie off");

    // R4 write masking
    bus_write(0, 16'hFFBF);
    bus_read(0, 16'h0080, "R4 FFBF");
    bus_write(0, 16'hFFFF);
    bus_read(0, 16'h00C0, "R4 FFFF");

    // R6 fault edge
    dev_error = 1'b1;
    tick(2);
    chk_bit("R6 not early", irq, 1'b0);
    tick(1);
    chk_bit("R6 irq", irq, 1'b1);
    bus_read(0, 16'h80C0, "R3 fault word");
    chk_bit("R3 signed negative", $signed(bus_rdata) < 0, 1'b1);
    chk_bit("R8 fault irq cleared", irq, 1'b0);

    // R11 foreign address
    bus_write(1, 16'h0000);
    bus_read(0, 16'h80C0, "R11 foreign write ignored");
    dev_error = 1'b0;
    tick(4);
    bus_read(0, 16'h00C0, "R3 no fault word");
    chk_bit("R3 signed non-negative", $signed(bus_rdata) < 0, 1'b0);
    dev_error = 1'b1;
    tick(3);
    chk_bit("R6 second irq", irq, 1'b1);
    bus_read(1, 16'h0000, "R11 foreign read");
    chk_bit("R11 irq kept", irq, 1'b1);
    bus_read(0, 16'h80C0, "R8 final read");
    chk_bit("R8 final irq", irq, 1'b0);

    tick(2);
    summary();
  end
endmodule